// File: doc/BRIEF.md
# Passive LCD Refresh Scanner

This block walks a frame buffer region in memory and paces a passive LCD panel. While video is running it presents one read address at a time to memory with a valid/ready handshake. Each accepted read moves a horizontal unit counter forward. At the end of a line it pulses the line clock, and at the end of the last line it wraps back to the start of the frame. The 4-bit word that memory returns is passed to the panel one cycle later, inverted if software asks for that. The block also drives an alternating-drive (AC) signal and a frame strobe.

Software sets the block up through a small write port with four registers: control, geometry, start address and end address. The block derives its horizontal and line limits from the pixel width, the pixel height, the colour mode and the dual-scan setting. A freeze request lets the current frame finish and then parks the scanner. Dropping video-enable and raising it again restarts the scan cleanly at the start address, so the address stays in step with the frame strobe.

Top module: `lcd_refresh_ctrl`

## Requirements
- R1: After reset, `rd_valid`, `line_clk`, `lcd_frame`, `lcd_frame_done`, `lcd_ac`, `lcd_valid` and `lcd_data` are all 0 and `rd_addr` is 0.
- R2: A line holds `(width/8)*3` accepted reads when colour mode (control bit 4) is set and split (control bit 3) is clear, and `width/4` reads otherwise. `line_clk` pulses for one cycle after the last read of each line. Width is geometry bits [DIM_W-1:0].
- R3: A frame holds `height/2` lines when split is set and `height` lines otherwise. Height is geometry bits [16+DIM_W-1:16].
- R4: `rd_addr` starts at the start address (select 2) and steps by one on each accepted read. It returns to the start address after the read at end address (select 3) minus one, and after the last read of a frame.
- R5: While `rd_valid` is high and `rd_ready` is low, the address, the counters and the panel outputs hold.
- R6: One cycle after an accepted read, `lcd_valid` is high and `lcd_data` equals `rd_data`, inverted bitwise when control bit 5 is set. In every other cycle both are 0.
- R7: `rd_valid` is high only when display-on (control bit 0) and video-enable (control bit 1) are both set and the scanner is not frozen. When it is low, nothing advances.
- R8: With freeze (control bit 2) set, the frame in progress completes and then the scanner stops. It stays stopped, even after freeze is cleared, until video-enable is cleared.
- R9: While video-enable is clear, the address is held at the start address and the counters and the frozen state are cleared. Scanning resumes from there.
- R10: `lcd_ac` toggles together with the last line pulse of each frame when control bit 6 is clear, and with every line pulse when it is set.
- R11: `lcd_frame` pulses one cycle after the first read of a frame is accepted. `lcd_frame_done` pulses one cycle after the line pulse of the frame's last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 geometry, 2 start, 3 end |
| wr_data | input | 32 | Register write data |
| rd_ready | input | 1 | Memory accepts the read this cycle |
| rd_data | input | 4 | Memory data for the presented address |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | ADDR_W | Read word address |
| line_clk | output | 1 | End-of-line pulse |
| lcd_frame | output | 1 | Start-of-frame strobe |
| lcd_frame_done | output | 1 | Frame-complete flag |
| lcd_ac | output | 1 | Alternating drive signal |
| lcd_valid | output | 1 | Panel data valid |
| lcd_data | output | 4 | Panel data |

## Verification
A register write takes effect at the clock edge that samples it. `rd_valid` and `rd_addr` show the new state in the next cycle. `lcd_valid`, `lcd_data`, `line_clk`, `lcd_frame` and `lcd_ac` follow an accepted read by exactly one cycle. `lcd_frame_done` comes one cycle after that. The bench updates its behavioural model at each rising edge from the same inputs the design saw. It compares every output on the falling edge that follows, so each result is checked in the cycle it is due. The directed checks count line pulses and valid beats observed at the ports.

// File: rtl/lcd_refresh_pkg.sv
package lcd_refresh_pkg;

    // Register select codes on the write port
    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_GEOM  = 2'd1;
    localparam logic [1:0] SEL_START = 2'd2;
    localparam logic [1:0] SEL_END   = 2'd3;

    // Low bit of the height field inside the geometry word
    localparam int GEOM_H_LSB = 16;
    localparam int CTRL_W     = 7;

    // Control word; disp_on sits in bit 0
    typedef struct packed {
        logic ac_line;
        logic invert;
        logic color8;
        logic split;
        logic freeze;
        logic vid_en;
        logic disp_on;
    } ctrl_t;

endpackage

// File: rtl/lcd_regs.sv
module lcd_regs
    import lcd_refresh_pkg::*;
#(
    parameter int DIM_W  = 12,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    output ctrl_t             ctrl,
    output logic [DIM_W-1:0]  width,
    output logic [DIM_W-1:0]  height,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] end_addr
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DIM_W-1:0]  width;
        logic [DIM_W-1:0]  height;
        logic [ADDR_W-1:0] start_a;
        logic [ADDR_W-1:0] end_a;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wr;

    assign unused_wr = ^wr_data;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_CTRL:  r_d.ctrl    = ctrl_t'(wr_data[CTRL_W-1:0]);
                SEL_GEOM: begin
                    r_d.width  = wr_data[DIM_W-1:0];
                    r_d.height = wr_data[GEOM_H_LSB +: DIM_W];
                end
                SEL_START: r_d.start_a = wr_data[ADDR_W-1:0];
                default:   r_d.end_a   = wr_data[ADDR_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl       = r_q.ctrl;
    assign width      = r_q.width;
    assign height     = r_q.height;
    assign start_addr = r_q.start_a;
    assign end_addr   = r_q.end_a;

endmodule

// File: rtl/lcd_geom.sv
module lcd_geom #(
    parameter int DIM_W = 12
) (
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic             color8,
    input  logic             split,
    output logic [DIM_W-1:0] h_last,
    output logic [DIM_W-1:0] l_last
);

    logic [DIM_W-1:0] eighth;
    logic [DIM_W-1:0] quarter;
    logic [DIM_W-1:0] sub_units;

    always_comb begin
        eighth    = width >> 3;
        quarter   = width >> 2;
        // three sub-pixel groups for every eight colour pixels
        sub_units = eighth + (eighth << 1);
        h_last    = (color8 && !split) ? sub_units - DIM_W'(1)
                                       : quarter - DIM_W'(1);
        l_last    = split ? (height >> 1) - DIM_W'(1)
                          : height - DIM_W'(1);
    end

endmodule

// File: rtl/lcd_scan.sv
module lcd_scan
    import lcd_refresh_pkg::*;
#(
    parameter int DIM_W  = 12,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [DIM_W-1:0]  h_last,
    input  logic [DIM_W-1:0]  l_last,
    input  logic              rd_ready,
    input  logic [3:0]        rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              line_clk,
    output logic              lcd_frame,
    output logic              lcd_frame_done,
    output logic              lcd_ac,
    output logic              lcd_valid,
    output logic [3:0]        lcd_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DIM_W-1:0]  hcnt;
        logic [DIM_W-1:0]  lcnt;
        logic              frozen;
        logic              ac;
        logic              line;
        logic              sof;
        logic              eof;
        logic              done;
        logic              dv;
        logic [3:0]        pdata;
    } scan_t;

    scan_t s_d, s_q;
    logic  run, acc, eol, eof;
    logic  ac_evt, addr_wrap;

    always_comb begin
        s_d       = s_q;
        run       = ctrl.disp_on && ctrl.vid_en && !s_q.frozen;
        acc       = run && rd_ready;
        eol       = acc && (s_q.hcnt == h_last);
        eof       = eol && (s_q.lcnt == l_last);
        addr_wrap = eof || ((s_q.addr + ADDR_W'(1)) == end_addr);
        ac_evt    = ctrl.ac_line ? eol : eof;

        s_d.line  = eol;
        s_d.sof   = acc && (s_q.hcnt == '0) && (s_q.lcnt == '0);
        s_d.eof   = eof;
        s_d.done  = s_q.eof;
        s_d.dv    = acc;
        s_d.pdata = acc ? (rd_data ^ {4{ctrl.invert}}) : 4'h0;

        if (acc) begin
            s_d.hcnt = eol ? '0 : s_q.hcnt + DIM_W'(1);
            if (eof)      s_d.lcnt = '0;
            else if (eol) s_d.lcnt = s_q.lcnt + DIM_W'(1);
            s_d.addr = addr_wrap ? start_addr : s_q.addr + ADDR_W'(1);
        end
        if (ac_evt)              s_d.ac     = !s_q.ac;
        if (eof && ctrl.freeze)  s_d.frozen = 1'b1;

        // video-enable low parks the scanner at the frame start
        if (!ctrl.vid_en) begin
            s_d.addr   = start_addr;
            s_d.hcnt   = '0;
            s_d.lcnt   = '0;
            s_d.frozen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid       = run;
    assign rd_addr        = s_q.addr;
    assign line_clk       = s_q.line;
    assign lcd_frame      = s_q.sof;
    assign lcd_frame_done = s_q.done;
    assign lcd_ac         = s_q.ac;
    assign lcd_valid      = s_q.dv;
    assign lcd_data       = s_q.pdata;

endmodule

// File: rtl/lcd_refresh_ctrl.sv
module lcd_refresh_ctrl
    import lcd_refresh_pkg::*;
#(
    parameter int DIM_W  = 12,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              rd_ready,
    input  logic [3:0]        rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              line_clk,
    output logic              lcd_frame,
    output logic              lcd_frame_done,
    output logic              lcd_ac,
    output logic              lcd_valid,
    output logic [3:0]        lcd_data
);

    ctrl_t             ctrl;
    logic [DIM_W-1:0]  width, height, h_last, l_last;
    logic [ADDR_W-1:0] start_addr, end_addr;

    lcd_regs #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ctrl       (ctrl),
        .width      (width),
        .height     (height),
        .start_addr (start_addr),
        .end_addr   (end_addr)
    );

    lcd_geom #(.DIM_W(DIM_W)) u_geom (
        .width  (width),
        .height (height),
        .color8 (ctrl.color8),
        .split  (ctrl.split),
        .h_last (h_last),
        .l_last (l_last)
    );

    lcd_scan #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_scan (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctrl           (ctrl),
        .start_addr     (start_addr),
        .end_addr       (end_addr),
        .h_last         (h_last),
        .l_last         (l_last),
        .rd_ready       (rd_ready),
        .rd_data        (rd_data),
        .rd_valid       (rd_valid),
        .rd_addr        (rd_addr),
        .line_clk       (line_clk),
        .lcd_frame      (lcd_frame),
        .lcd_frame_done (lcd_frame_done),
        .lcd_ac         (lcd_ac),
        .lcd_valid      (lcd_valid),
        .lcd_data       (lcd_data)
    );

endmodule

// File: rtl/lcd_refresh_ctrl_sva.sv
module lcd_refresh_ctrl_sva #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              line_clk,
    input logic              lcd_frame_done,
    input logic              lcd_ac,
    input logic              lcd_valid,
    input logic [3:0]        lcd_data
);

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !wr_en) |=> $stable(rd_addr));

    p_beat_follows_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> lcd_valid);

    p_blank_without_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_ready) |=> (!lcd_valid && lcd_data == 4'h0));

    p_ac_on_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lcd_ac) |-> line_clk);

    p_done_after_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_frame_done |-> $past(line_clk));

endmodule

bind lcd_refresh_ctrl lcd_refresh_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .rd_ready       (rd_ready),
    .rd_valid       (rd_valid),
    .rd_addr        (rd_addr),
    .line_clk       (line_clk),
    .lcd_frame_done (lcd_frame_done),
    .lcd_ac         (lcd_ac),
    .lcd_valid      (lcd_valid),
    .lcd_data       (lcd_data)
);

// File: tb/lcd_refresh_ctrl_bench.sv
module lcd_refresh_ctrl_bench;

    localparam int ADDR_W = 20;
    localparam int DISP = 1, VID = 2, FRZ = 4, SPL = 8, C8 = 16, INV = 32, ACL = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = 2'd0;
    logic [31:0]       wr_data = 32'd0;
    logic              rd_ready = 1'b0;
    logic [3:0]        rd_data;
    logic              rd_valid, line_clk, lcd_frame, lcd_frame_done, lcd_ac, lcd_valid;
    logic [ADDR_W-1:0] rd_addr;
    logic [3:0]        lcd_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign rd_data = rd_addr[3:0] + 4'd5;

    lcd_refresh_ctrl #(.ADDR_W(ADDR_W)) u_lcd_refresh_ctrl (.*);

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // ready pattern
    logic [7:0] lfsr = 8'hA5;
    bit rdy_rand = 0, stall = 0;
    always @(negedge clk) begin
        lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rd_ready <= stall ? 1'b0 : (rdy_rand ? lfsr[0] : 1'b1);
    end

    // behavioural reference model
    int m_ctrl, m_w, m_h, m_start, m_end;
    int m_addr, m_hc, m_lc, m_frozen, m_ac;
    int e_line, e_frame, e_eof, e_done, e_dv, e_pd;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_w = 0; m_h = 0; m_start = 0; m_end = 0;
            m_addr = 0; m_hc = 0; m_lc = 0; m_frozen = 0; m_ac = 0;
            e_line = 0; e_frame = 0; e_eof = 0; e_done = 0; e_dv = 0; e_pd = 0;
        end else begin
            int units, lines;
            bit go, acc, eol, eof;
            units = ((m_ctrl & C8) && !(m_ctrl & SPL)) ? (m_w / 8) * 3 : m_w / 4;
            lines = (m_ctrl & SPL) ? m_h / 2 : m_h;
            go    = (m_ctrl & DISP) && (m_ctrl & VID) && !m_frozen;
            acc   = go && rd_ready;
            eol   = acc && (m_hc == units - 1);
            eof   = eol && (m_lc == lines - 1);
            e_done  = e_eof;
            e_eof   = eof;
            e_line  = eol;
            e_frame = acc && m_hc == 0 && m_lc == 0;
            e_dv    = acc;
            e_pd    = acc ? (((m_addr + 5) & 15) ^ ((m_ctrl & INV) ? 15 : 0)) : 0;
            if (acc) begin
                if (eol) begin m_hc = 0; m_lc = eof ? 0 : m_lc + 1; end
                else m_hc++;
                m_addr = (eof || m_addr + 1 == m_end) ? m_start : m_addr + 1;
            end
            if ((m_ctrl & ACL) ? eol : eof) m_ac ^= 1;
            if (eof && (m_ctrl & FRZ)) m_frozen = 1;
            if (!(m_ctrl & VID)) begin
                m_addr = m_start; m_hc = 0; m_lc = 0; m_frozen = 0;
            end
            if (wr_en) case (wr_sel)
                2'd0: m_ctrl = int'(wr_data[6:0]);
                2'd1: begin m_w = int'(wr_data[11:0]); m_h = int'(wr_data[27:16]); end
                2'd2: m_start = int'(wr_data[19:0]);
                default: m_end = int'(wr_data[19:0]);
            endcase
        end
    end

    // per-cycle comparison and port-side monitors
    bit started = 0;
    int units_run = 0, last_units = 0, lines_run = 0, last_lines = 0;
    int max_addr = 0, ac_flips = 0, line_cnt = 0;
    logic ac_prev = 1'b0;
    always @(negedge clk) begin
        if (started) begin
            chk("R7",  "rd_valid", rd_valid,
                ((m_ctrl & DISP) && (m_ctrl & VID) && !m_frozen) ? 1 : 0);
            chk("R4",  "rd_addr", int'(rd_addr), m_addr);
            chk("R2",  "line_clk", line_clk, e_line);
            chk("R11", "lcd_frame", lcd_frame, e_frame);
            chk("R11", "lcd_frame_done", lcd_frame_done, e_done);
            chk("R10", "lcd_ac", lcd_ac, m_ac);
            chk("R6",  "lcd_valid", lcd_valid, e_dv);
            chk("R6",  "lcd_data", int'(lcd_data), e_pd);
            if (lcd_frame) begin last_lines = lines_run; lines_run = 0; end
            if (lcd_valid) units_run++;
            if (line_clk) begin
                last_units = units_run; units_run = 0; lines_run++; line_cnt++;
            end
            if (rd_valid && int'(rd_addr) > max_addr) max_addr = int'(rd_addr);
            if (lcd_ac != ac_prev) ac_flips++;
            ac_prev = lcd_ac;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(int w, int h, int s, int e, int c);
        wr(2'd0, 0);
        wr(2'd1, (h << 16) | w);
        wr(2'd2, s);
        wr(2'd3, e);
        wr(2'd0, c);
        max_addr = 0; ac_flips = 0; line_cnt = 0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "rd_addr", int'(rd_addr), 0);
        chk("R1", "outputs", {line_clk, lcd_frame, lcd_frame_done, lcd_ac, lcd_valid}, 0);
        chk("R1", "lcd_data", int'(lcd_data), 0);
        started = 1;

        // R2/R3 monochrome: 32/4 = 8 units, 4 lines
        cfg(32, 4, 'h100, 'h1000, DISP | VID);
        wait_cyc(100);
        chk("R2", "units mono", last_units, 8);
        chk("R3", "lines full", last_lines, 4);

        // R2 colour, no split: (32/8)*3 = 12 units
        cfg(32, 4, 'h100, 'h1000, DISP | VID | C8);
        wait_cyc(150);
        chk("R2", "units colour", last_units, 12);
        chk("R3", "lines colour", last_lines, 4);

        // R2/R3 colour with split: 8 units, 2 lines
        cfg(32, 4, 'h100, 'h1000, DISP | VID | C8 | SPL);
        wait_cyc(80);
        chk("R2", "units split", last_units, 8);
        chk("R3", "lines split", last_lines, 2);

        // R4 wrap at end address, R6 inversion, R10 per-line AC, random ready
        rdy_rand = 1;
        cfg(16, 4, 'h200, 'h20A, DISP | VID | INV | ACL);
        wait_cyc(200);
        chk("R4", "max address", max_addr, 'h209);
        chk("R10", "ac flips vs lines", ac_flips, line_cnt);

        // R5 stall holds
        begin
            int a;
            stall = 1;
            wait_cyc(3);
            a = int'(rd_addr);
            wait_cyc(5);
            chk("R5", "addr held", int'(rd_addr), a);
            chk("R5", "no beat", lcd_valid, 0);
            stall = 0;
        end
        rdy_rand = 0;

        // R7 display off blanks
        begin
            int a;
            wr(2'd0, VID);
            wait_cyc(2);
            a = int'(rd_addr);
            chk("R7", "no request", rd_valid, 0);
            wait_cyc(5);
            chk("R7", "addr held", int'(rd_addr), a);
            chk("R7", "no beat", lcd_valid, 0);
        end

        // R9 re-enable restarts at start address
        wr(2'd0, DISP | VID);
        wait_cyc(13);
        wr(2'd0, DISP);
        wr(2'd0, DISP | VID);
        chk("R9", "restart addr", int'(rd_addr), 'h200);
        chk("R9", "running", rd_valid, 1);

        // R8 freeze completes the frame then parks
        cfg(32, 4, 'h100, 'h1000, DISP | VID);
        wait_cyc(40);
        wr(2'd0, DISP | VID | FRZ);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (lcd_frame_done) break;
        end
        wait_cyc(1);
        chk("R8", "frame completed lines", lines_run, 4);
        chk("R8", "stopped", rd_valid, 0);
        wait_cyc(10);
        chk("R8", "still stopped", rd_valid, 0);
        chk("R8", "no beat", lcd_valid, 0);
        wr(2'd0, DISP | VID);
        wait_cyc(5);
        chk("R8", "stays frozen", rd_valid, 0);
        wr(2'd0, DISP);
        wr(2'd0, DISP | VID);
        chk("R9", "addr after unfreeze", int'(rd_addr), 'h100);
        chk("R9", "running after unfreeze", rd_valid, 1);
        wait_cyc(20);

        finish_run();
    end

endmodule